// File: doc/BRIEF.md
# BCD Time-of-Day Register Clock

This block keeps a running calendar as thirteen separate 4-bit BCD digit registers: tenths of a second, seconds, minutes, hours, day of month and month (each of the last five split into a units digit and a tens digit), a day-of-week digit, and a year digit. The year digit does not count years. It holds a one-hot marker of the position within the four-year leap cycle. Hours run on a 24-hour scale and months run from 1 to 12.

A CPU reaches each digit at its own word-spaced byte offset, through a narrow bus with a 4-bit data path and separate read and write strobes. Read data is registered. The clock advances on a one-cycle input pulse that arrives at 10 Hz. Software sets the time by writing digits one at a time. Any digit write freezes counting, so a half-written date is never advanced. A commit write then releases the clock.

Top module: `tod_clock`

## Requirements
- R1: After a synchronous reset the digits read as 00:00:00.0, day 01, month 01, day of week 1 and year code 1, and `bus_rdata` is 0.
- R2: A read strobe with a word-aligned offset of 0x04 times n (n = 1 to 13) returns, one cycle later on `bus_rdata`, the digit in this order: tenths, seconds units, seconds tens, minutes units, minutes tens, hours units, hours tens, day units, day tens, day of week, month units, month tens, year. `bus_rdata` holds its value while `bus_rd` is low.
- R3: A read of any other offset returns 0. This covers 0x00, 0x38, 0x3C and any offset that is not a multiple of 4.
- R4: A write to a digit offset replaces that digit with `bus_wdata` on the next clock edge. It also suspends counting: ticks are dropped until a commit.
- R5: A write to offset 0x38 with data bit 0 set is a commit. It ends the suspension started by a digit write. A write to 0x38 with bit 0 clear leaves the clock suspended.
- R6: A tick that arrives in the same cycle as any write strobe is dropped, including writes to 0x38 and to unmapped offsets.
- R7: A tick advances tenths. Tenths wrap from 9 to 0 and carry into seconds. Seconds and minutes wrap from 59 to 00 and carry. Hours wrap from 23 to 00 and carry into the day.
- R8: The day-of-week digit advances each time the hours wrap, and goes from 7 back to 1.
- R9: The day wraps to 01 and carries into the month after day 30 (April, June, September, November), after day 31 (the other long months), after day 28 in February, or after day 29 in February when the year code is 8. The month counts in BCD, so 09 is followed by 10, and 12 wraps to 01.
- R10: The year code is 1, 2 or 4 for three, two or one years before a leap year, and 8 for a leap year. It rotates left by one bit on each December-to-January rollover, going from 8 back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse at 10 Hz that advances the clock |
| bus_addr | input | ADDR_W (6) | Byte offset of the access |
| bus_wdata | input | 4 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 4 | Registered read data |

## Verification
The bench drives the clock to the last tenth of a day and ticks once. It does this for each month-length class, for February in both leap and non-leap years, for the BCD step from month 09 to 10, and for December in several year codes. A design with a wrong month table or a wrong leap test would show 29 February in a non-leap year, or would skip 30 April. A wrong year rotation would show up as a code of 16 or 0 after a leap year. The bench also checks that a half-written time stays frozen until a commit with bit 0 set, that a tick arriving with any write is lost rather than deferred, and that unmapped and misaligned offsets read 0. A design that got these wrong would advance a partly set time, would count twice, or would return stale digits.

// File: rtl/tod_pkg.sv
`timescale 1ns/1ps
package tod_pkg;
  localparam int DIGIT_W    = 4;
  localparam int NUM_DIGITS = 13;
  localparam int IDX_W      = $clog2(NUM_DIGITS);

  // word index (offset >> 2) of the first digit and of the commit word
  localparam int FIRST_WORD  = 1;
  localparam int COMMIT_WORD = FIRST_WORD + NUM_DIGITS;

  // digit positions; this order fixes the address of each digit
  localparam int IX_TENTHS = 0;
  localparam int IX_SEC_U  = 1;
  localparam int IX_SEC_T  = 2;
  localparam int IX_MIN_U  = 3;
  localparam int IX_MIN_T  = 4;
  localparam int IX_HR_U   = 5;
  localparam int IX_HR_T   = 6;
  localparam int IX_DAY_U  = 7;
  localparam int IX_DAY_T  = 8;
  localparam int IX_DOW    = 9;
  localparam int IX_MON_U  = 10;
  localparam int IX_MON_T  = 11;
  localparam int IX_YEAR   = 12;

  // two-digit counters in carry order: seconds, minutes, hours, day, month
  localparam int NUM_PAIRS = 5;
  localparam int PAIR_UNITS [NUM_PAIRS] = '{IX_SEC_U, IX_MIN_U, IX_HR_U, IX_DAY_U, IX_MON_U};
  localparam int PAIR_TENS  [NUM_PAIRS] = '{IX_SEC_T, IX_MIN_T, IX_HR_T, IX_DAY_T, IX_MON_T};
  localparam int PAIR_BASE  [NUM_PAIRS] = '{0, 0, 0, 1, 1};
  localparam int PAIR_DAY   = 3;
  localparam int PAIR_MON   = 4;

  localparam int DOW_FIRST = 1;
  localparam int DOW_LAST  = 7;
  localparam int YEAR_W    = 4;
  localparam logic [YEAR_W-1:0] LEAP_CODE = 4'b1000;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef digit_t [NUM_DIGITS-1:0] digit_vec_t;

  function automatic digit_vec_t reset_digits();
    digit_vec_t v;
    v = '0;
    v[IX_DAY_U] = digit_t'(1);
    v[IX_DOW]   = digit_t'(DOW_FIRST);
    v[IX_MON_U] = digit_t'(1);
    v[IX_YEAR]  = digit_t'(1);
    return v;
  endfunction
endpackage

// File: rtl/tod_addr_decode.sv
`timescale 1ns/1ps
module tod_addr_decode
  import tod_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              digit_hit,
  output logic [IDX_W-1:0]  digit_idx,
  output logic              commit_hit
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              aligned;

  assign word    = addr[ADDR_W-1:2];
  assign aligned = (addr[1:0] == 2'b00);

  always_comb begin
    digit_hit  = aligned && (word >= WORD_W'(FIRST_WORD)) &&
                 (word < WORD_W'(FIRST_WORD + NUM_DIGITS));
    digit_idx  = IDX_W'(word - WORD_W'(FIRST_WORD));
    commit_hit = aligned && (word == WORD_W'(COMMIT_WORD));
  end
endmodule

// File: rtl/tod_month_len.sv
`timescale 1ns/1ps
module tod_month_len
  import tod_pkg::*;
(
  input  digit_t             mon_t,
  input  digit_t             mon_u,
  input  logic [YEAR_W-1:0]  year,
  output digit_t             last_t,
  output digit_t             last_u
);
  always_comb begin
    last_t = digit_t'(3);
    last_u = digit_t'(1);
    if (mon_t == digit_t'(0)) begin
      case (mon_u)
        digit_t'(2): begin
          last_t = digit_t'(2);
          last_u = (year == LEAP_CODE) ? digit_t'(9) : digit_t'(8);
        end
        digit_t'(4), digit_t'(6), digit_t'(9): last_u = digit_t'(0);
        default: last_u = digit_t'(1);
      endcase
    end else if (mon_u == digit_t'(1)) begin
      last_u = digit_t'(0);
    end
  end
endmodule

// File: rtl/tod_bcd_pair.sv
`timescale 1ns/1ps
module tod_bcd_pair
  import tod_pkg::*;
#(
  parameter int BASE_UNITS = 0
) (
  input  logic   en,
  input  digit_t units,
  input  digit_t tens,
  input  digit_t last_t,
  input  digit_t last_u,
  output digit_t units_nxt,
  output digit_t tens_nxt,
  output logic   carry
);
  always_comb begin
    units_nxt = units;
    tens_nxt  = tens;
    carry     = 1'b0;
    if (en) begin
      if ((units == last_u) && (tens == last_t)) begin
        units_nxt = digit_t'(BASE_UNITS);
        tens_nxt  = '0;
        carry     = 1'b1;
      end else if (units == digit_t'(9)) begin
        units_nxt = '0;
        tens_nxt  = tens + digit_t'(1);
      end else begin
        units_nxt = units + digit_t'(1);
      end
    end
  end
endmodule

// File: rtl/tod_calendar_step.sv
`timescale 1ns/1ps
module tod_calendar_step
  import tod_pkg::*;
(
  input  digit_vec_t cur,
  output digit_vec_t nxt
);
  logic   [NUM_PAIRS:0]   en;
  logic   [NUM_PAIRS-1:0] carry;
  digit_t                 lim_t [NUM_PAIRS];
  digit_t                 lim_u [NUM_PAIRS];
  digit_t                 pu    [NUM_PAIRS];
  digit_t                 pt    [NUM_PAIRS];
  digit_t                 mlen_t, mlen_u;

  tod_month_len u_mlen (
    .mon_t  (cur[IX_MON_T]),
    .mon_u  (cur[IX_MON_U]),
    .year   (cur[IX_YEAR]),
    .last_t (mlen_t),
    .last_u (mlen_u)
  );

  always_comb begin
    lim_t[0] = digit_t'(5); lim_u[0] = digit_t'(9);
    lim_t[1] = digit_t'(5); lim_u[1] = digit_t'(9);
    lim_t[2] = digit_t'(2); lim_u[2] = digit_t'(3);
    lim_t[PAIR_DAY] = mlen_t; lim_u[PAIR_DAY] = mlen_u;
    lim_t[PAIR_MON] = digit_t'(1); lim_u[PAIR_MON] = digit_t'(2);
  end

  assign en[0] = (cur[IX_TENTHS] == digit_t'(9));

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    tod_bcd_pair #(.BASE_UNITS(PAIR_BASE[p])) u_pair (
      .en        (en[p]),
      .units     (cur[PAIR_UNITS[p]]),
      .tens      (cur[PAIR_TENS[p]]),
      .last_t    (lim_t[p]),
      .last_u    (lim_u[p]),
      .units_nxt (pu[p]),
      .tens_nxt  (pt[p]),
      .carry     (carry[p])
    );
    assign en[p+1] = carry[p];
  end

  always_comb begin
    nxt = cur;
    nxt[IX_TENTHS] = en[0] ? '0 : cur[IX_TENTHS] + digit_t'(1);
    for (int p = 0; p < NUM_PAIRS; p++) begin
      nxt[PAIR_UNITS[p]] = pu[p];
      nxt[PAIR_TENS[p]]  = pt[p];
    end
    if (en[PAIR_DAY])
      nxt[IX_DOW] = (cur[IX_DOW] == digit_t'(DOW_LAST)) ? digit_t'(DOW_FIRST)
                                                       : cur[IX_DOW] + digit_t'(1);
    if (carry[PAIR_MON])
      nxt[IX_YEAR] = {cur[IX_YEAR][YEAR_W-2:0], cur[IX_YEAR][YEAR_W-1]};
  end
endmodule

// File: rtl/tod_digit_bank.sv
`timescale 1ns/1ps
module tod_digit_bank
  import tod_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr,
  input  logic              rd,
  input  logic              digit_hit,
  input  logic [IDX_W-1:0]  digit_idx,
  input  logic              commit_hit,
  input  digit_t            wdata,
  input  digit_vec_t        step_val,
  output digit_vec_t        digits,
  output logic              hold,
  output digit_t            rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      digits <= reset_digits();
      hold   <= 1'b0;
    end else if (wr) begin
      if (digit_hit) begin
        digits[digit_idx] <= wdata;
        hold              <= 1'b1;
      end else if (commit_hit && wdata[0]) begin
        hold <= 1'b0;
      end
    end else if (tick && !hold) begin
      digits <= step_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata <= '0;
    else if (rd)
      rdata <= digit_hit ? digits[digit_idx] : '0;
  end
endmodule

// File: rtl/tod_clock.sv
`timescale 1ns/1ps
module tod_clock
  import tod_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DIGIT_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DIGIT_W-1:0] bus_rdata
);
  logic             digit_hit, commit_hit, hold_q;
  logic [IDX_W-1:0] digit_idx;
  digit_vec_t       digit_q, step_val;

  tod_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr       (bus_addr),
    .digit_hit  (digit_hit),
    .digit_idx  (digit_idx),
    .commit_hit (commit_hit)
  );

  tod_calendar_step u_step (
    .cur (digit_q),
    .nxt (step_val)
  );

  tod_digit_bank u_bank (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .wr         (bus_wr),
    .rd         (bus_rd),
    .digit_hit  (digit_hit),
    .digit_idx  (digit_idx),
    .commit_hit (commit_hit),
    .wdata      (bus_wdata),
    .step_val   (step_val),
    .digits     (digit_q),
    .hold       (hold_q),
    .rdata      (bus_rdata)
  );
endmodule

// File: rtl/tod_clock_chk.sv
`timescale 1ns/1ps
module tod_clock_chk
  import tod_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input logic               clk,
  input logic               rst,
  input logic               tick,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DIGIT_W-1:0] bus_wdata,
  input logic               bus_wr,
  input logic               bus_rd,
  input logic [DIGIT_W-1:0] bus_rdata,
  input digit_vec_t         digit_q,
  input logic               hold_q
);
  localparam int WORD_W = ADDR_W - 2;

  logic [WORD_W-1:0] word;
  logic              mapped;
  logic [IDX_W-1:0]  idx;
  logic [IDX_W-1:0]  wr_idx_q;
  digit_t            wr_data_q;

  assign word   = bus_addr[ADDR_W-1:2];
  assign mapped = (bus_addr[1:0] == 2'b00) && (word >= WORD_W'(FIRST_WORD)) &&
                  (word < WORD_W'(FIRST_WORD + NUM_DIGITS));
  assign idx    = IDX_W'(word - WORD_W'(FIRST_WORD));

  always_ff @(posedge clk) begin
    wr_idx_q  <= idx;
    wr_data_q <= bus_wdata;
  end

  // R3: unmapped reads return zero
  assert_unmapped_zero_R3: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !mapped) |=> (bus_rdata == '0));

  // R4: a digit write lands in the addressed digit
  assert_write_lands_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && mapped) |=> (digit_q[wr_idx_q] == wr_data_q));

  // R4: while suspended, a cycle without a write changes nothing
  assert_hold_freezes_R4: assert property (@(posedge clk) disable iff (rst)
    (hold_q && !bus_wr) |=> $stable(digit_q));

  // R6: a write to a non-digit offset leaves every digit unchanged
  assert_write_drops_tick_R6: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !mapped) |=> $stable(digit_q));

  // R7: tenths at 9 wrap to 0 on an accepted tick
  assert_tenths_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    (tick && !bus_wr && !hold_q && digit_q[IX_TENTHS] == digit_t'(9))
      |=> (digit_q[IX_TENTHS] == '0));

  // R10: when the year changes without a write, it is a left rotation
  assert_year_rotate_R10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(bus_wr) && (digit_q[IX_YEAR] != $past(digit_q[IX_YEAR])))
      |-> (digit_q[IX_YEAR] == {$past(digit_q[IX_YEAR][YEAR_W-2:0]),
                                 $past(digit_q[IX_YEAR][YEAR_W-1])}));
endmodule

bind tod_clock tod_clock_chk #(.ADDR_W(ADDR_W)) u_tod_chk (
  .clk       (clk),
  .rst       (rst),
  .tick      (tick),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .digit_q   (digit_q),
  .hold_q    (hold_q)
);

// File: tb/tb_tod_clock.sv
`timescale 1ns/1ps
module tb_tod_clock;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [3:0] bus_wdata = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [3:0] bus_rdata;

  int    checks = 0;
  int    errors = 0;
  bit    done = 0;
  string phase = "R1";

  // reference model state
  int m[13];
  bit mhold;
  int exp_rdata;

  always #5 clk = ~clk;

  tod_clock #(.ADDR_W(6)) dut (
    .clk(clk), .rst(rst), .tick(tick), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  function automatic int days_in(int mon, int yr);
    case (mon)
      2:            return (yr == 8) ? 29 : 28;
      4, 6, 9, 11:  return 30;
      default:      return 31;
    endcase
  endfunction

  function automatic bit is_digit(int a);
    return (a % 4 == 0) && (a / 4 >= 1) && (a / 4 <= 13);
  endfunction

  task automatic model_advance();
    int s, mi, h, dy, mo;
    if (m[0] < 9) begin m[0]++; return; end
    m[0] = 0;
    s = m[2] * 10 + m[1] + 1;
    if (s < 60) begin m[2] = s / 10; m[1] = s % 10; return; end
    m[2] = 0; m[1] = 0;
    mi = m[4] * 10 + m[3] + 1;
    if (mi < 60) begin m[4] = mi / 10; m[3] = mi % 10; return; end
    m[4] = 0; m[3] = 0;
    h = m[6] * 10 + m[5] + 1;
    if (h < 24) begin m[6] = h / 10; m[5] = h % 10; return; end
    m[6] = 0; m[5] = 0;
    m[9] = (m[9] >= 7) ? 1 : m[9] + 1;
    dy = m[8] * 10 + m[7];
    mo = m[11] * 10 + m[10];
    if (dy < days_in(mo, m[12])) begin dy++; end
    else begin
      dy = 1; mo++;
      if (mo > 12) begin
        mo = 1;
        m[12] = (m[12] == 8) ? 1 : m[12] * 2;
      end
    end
    m[8] = dy / 10; m[7] = dy % 10;
    m[11] = mo / 10; m[10] = mo % 10;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      foreach (m[i]) m[i] = 0;
      m[7] = 1; m[9] = 1; m[10] = 1; m[12] = 1;
      mhold = 0; exp_rdata = 0;
    end else begin
      if (bus_rd) exp_rdata = is_digit(bus_addr) ? m[bus_addr / 4 - 1] : 0;
      if (bus_wr) begin
        if (is_digit(bus_addr)) begin m[bus_addr / 4 - 1] = bus_wdata; mhold = 1; end
        else if (bus_addr == 6'h38 && bus_wdata[0]) mhold = 0;
      end else if (tick && !mhold) model_advance();
    end
  end

  task automatic cyc(input bit w, input bit r, input int a, input int d, input bit t);
    bus_wr = w; bus_rd = r; bus_addr = 6'(a); bus_wdata = 4'(d); tick = t;
    @(posedge clk);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; tick = 0;
    if (r) begin
      checks++;
      if (bus_rdata !== 4'(exp_rdata)) begin
        errors++;
        $display("FAIL %s model at %h: got %0h expected %0h", phase, a, bus_rdata, exp_rdata);
      end
    end
  endtask

  task automatic rd_exp(input int a, input int v, input string req);
    cyc(0, 1, a, 0, 0);
    checks++;
    if (bus_rdata !== 4'(v)) begin
      errors++;
      $display("FAIL %s at %h: got %0h expected %0h", req, a, bus_rdata, v);
    end
  endtask

  task automatic wr(input int a, input int d);
    cyc(1, 0, a, d, 0);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1);
  endtask

  task automatic set_cal(input int tn, input int s, input int mi, input int h,
                         input int dy, input int dw, input int mo, input int yr);
    wr(6'h04, tn);     wr(6'h08, s % 10); wr(6'h0C, s / 10);
    wr(6'h10, mi % 10); wr(6'h14, mi / 10);
    wr(6'h18, h % 10); wr(6'h1C, h / 10);
    wr(6'h20, dy % 10); wr(6'h24, dy / 10);
    wr(6'h28, dw);
    wr(6'h2C, mo % 10); wr(6'h30, mo / 10);
    wr(6'h34, yr);
    wr(6'h38, 1);
  endtask

  task automatic roll_day(input int mo, input int dy, input int yr,
                          input int edy, input int emo, input int eyr, input string req);
    phase = req;
    set_cal(9, 59, 59, 23, dy, 3, mo, yr);
    ticks(1);
    rd_exp(6'h20, edy % 10, req); rd_exp(6'h24, edy / 10, req);
    rd_exp(6'h2C, emo % 10, req); rd_exp(6'h30, emo / 10, req);
    rd_exp(6'h34, eyr, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset values through R2 address map
    phase = "R1";
    rd_exp(6'h04, 0, "R1"); rd_exp(6'h08, 0, "R1"); rd_exp(6'h1C, 0, "R1");
    rd_exp(6'h20, 1, "R1"); rd_exp(6'h24, 0, "R1"); rd_exp(6'h28, 1, "R1");
    rd_exp(6'h2C, 1, "R1"); rd_exp(6'h30, 0, "R1"); rd_exp(6'h34, 1, "R1");
    // R2 read data holds while rd is low
    phase = "R2";
    cyc(0, 0, 6'h04, 0, 0);
    checks++;
    if (bus_rdata !== 4'd1) begin errors++; $display("FAIL R2 hold: got %0h expected 1", bus_rdata); end
    // R3 unmapped reads
    phase = "R3";
    rd_exp(6'h38, 0, "R3"); rd_exp(6'h20, 1, "R3"); rd_exp(6'h00, 0, "R3");
    rd_exp(6'h20, 1, "R3"); rd_exp(6'h21, 0, "R3"); rd_exp(6'h2C, 1, "R3");
    rd_exp(6'h3C, 0, "R3");
    // R4 digit write and suspension
    phase = "R4";
    wr(6'h08, 7);
    rd_exp(6'h08, 7, "R4");
    ticks(5);
    rd_exp(6'h04, 0, "R4");
    // R5 commit with bit 0 clear keeps suspension; bit 0 set releases
    phase = "R5";
    wr(6'h38, 2);
    ticks(3);
    rd_exp(6'h04, 0, "R5");
    wr(6'h38, 1);
    ticks(1);
    rd_exp(6'h04, 1, "R5");
    // R6 ticks coincident with writes are dropped
    phase = "R6";
    cyc(1, 0, 6'h38, 1, 1);
    rd_exp(6'h04, 1, "R6");
    cyc(1, 0, 6'h3C, 5, 1);
    rd_exp(6'h04, 1, "R6");
    ticks(1);
    rd_exp(6'h04, 2, "R6");
    // R7 R8 full carry chain into the day and day of week
    phase = "R7";
    set_cal(9, 59, 59, 23, 7, 7, 3, 1);
    ticks(1);
    rd_exp(6'h04, 0, "R7"); rd_exp(6'h08, 0, "R7"); rd_exp(6'h0C, 0, "R7");
    rd_exp(6'h10, 0, "R7"); rd_exp(6'h14, 0, "R7"); rd_exp(6'h18, 0, "R7");
    rd_exp(6'h1C, 0, "R7"); rd_exp(6'h20, 8, "R7");
    rd_exp(6'h28, 1, "R8");
    set_cal(9, 59, 59, 23, 8, 3, 3, 1);
    ticks(1);
    rd_exp(6'h28, 4, "R8");
    // R9 month lengths and leap February
    roll_day(4, 30, 2, 1, 5, 2, "R9");
    roll_day(1, 30, 1, 31, 1, 1, "R9");
    roll_day(1, 31, 1, 1, 2, 1, "R9");
    roll_day(2, 28, 4, 1, 3, 4, "R9");
    roll_day(2, 28, 8, 29, 2, 8, "R9");
    roll_day(2, 29, 8, 1, 3, 8, "R9");
    roll_day(9, 30, 1, 1, 10, 1, "R9");
    roll_day(11, 30, 1, 1, 12, 1, "R9");
    // R10 year code rotation on December rollover
    roll_day(12, 31, 8, 1, 1, 1, "R10");
    roll_day(12, 31, 1, 1, 1, 2, "R10");
    roll_day(12, 31, 2, 1, 1, 4, "R10");
    roll_day(12, 31, 4, 1, 1, 8, "R10");
    // R7 long run compared with the model on every read
    phase = "R7";
    set_cal(0, 40, 59, 23, 28, 6, 2, 4);
    for (int i = 0; i < 3000; i++)
      cyc(0, 1, 4 * (1 + i % 13), 0, (i % 3) != 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule